// File: doc/BRIEF.md
# MDIO Management Register Controller

This block gives software a two-register window onto the management registers of an Ethernet PHY. A command word names the PHY, the register inside it and the direction. Setting the start/busy bit in that word makes the block send one clause-22 management frame on a clock/data pair. On a read, the block collects the 16 bits returned by the PHY into the data register.

Software follows a simple polling discipline. It waits for busy to read 0 and, for a write, loads the data register. It then writes the command with busy set and polls until busy falls again. The management clock is produced by dividing the system clock by an even parameter. The data pin is tri-state: the block drives it while it owns the line and releases it while the PHY answers.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the command word (offset 0x14) and the data word (offset 0x18) both read 0, `mdc` is low and `mdio_oe` is low.
- R2: The command word reads back as {16'b0, phy[4:0] at bits 15:11, reg[4:0] at bits 10:6, 4'b0, write flag at bit 1, busy at bit 0}.
- R3: The data word holds a 16-bit value in bits 15:0 (upper bits read 0). A bus write to it while idle replaces that value.
- R4: A command write with bit 0 set while idle starts a frame. Busy reads 1 for exactly 64 MDC periods (64*DIV clocks) and clears on the clock where the final MDC falling edge happens.
- R5: A write frame (bit 1 = 1) puts 64 bits on `mdio_o` with `mdio_oe` high throughout, MSB first: 32 ones, 01, opcode 01, phy, reg, turnaround 10, then the data word.
- R6: A read frame (bit 1 = 0) sends 32 ones, 01, opcode 10, phy, reg with `mdio_oe` high. `mdio_oe` is low for the last 18 bit times. The 16 bits sampled in bit times 48..63, MSB first, are in the data word when busy clears.
- R7: `mdc` is low while idle and has a period of DIV system clocks, half high and half low. `mdio_o` changes only after an MDC falling edge, and `mdio_i` is sampled at MDC rising edges.
- R8: While busy, writes to the command word and to the data word are ignored. Neither the frame nor the readable state changes.
- R9: A command write with bit 0 clear updates the phy, reg and write fields but starts no frame: busy stays 0 and `mdc` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions assume the bus follows the polling discipline. They also assume that `mdio_i` changes only while MDC is low, which matches what a clause-22 PHY does after a falling edge. The bench drives its PHY model's data bit only right after MDC falls, and only during the data phase of a read. It holds the bit at 0 elsewhere. It also issues bus writes during a frame on purpose, but only to confirm they are ignored, never to hand over a new command.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DIV = 4,
  parameter logic [ADDR_W-1:0] CMD_OFS = 'h14,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int HALF = DIV / 2;
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int DRIVEN_BITS = 46;
  localparam int DATA_FIRST = 48;

  logic          busy_q, wr_q, mdc_q;
  logic [4:0]    phy_q, reg_q;
  logic [15:0]   data_q;
  logic [63:0]   shift_q;
  logic [5:0]    bit_q;
  logic [CW-1:0] cnt_q;

  wire cmd_sel = bus_wr && (bus_addr == CMD_OFS);
  wire dat_sel = bus_wr && (bus_addr == DATA_OFS);
  wire start   = cmd_sel && !busy_q && bus_wdata[0];
  wire tick    = busy_q && (cnt_q == CW'(HALF - 1));
  wire last    = (bit_q == 6'd63);
  wire nw      = bus_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      mdc_q   <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      data_q  <= '0;
      shift_q <= '0;
      bit_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (!busy_q || tick) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;

      if (cmd_sel && !busy_q) begin
        wr_q  <= nw;
        phy_q <= bus_wdata[15:11];
        reg_q <= bus_wdata[10:6];
      end
      if (dat_sel && !busy_q) data_q <= bus_wdata[15:0];

      if (start) begin
        busy_q  <= 1'b1;
        bit_q   <= '0;
        mdc_q   <= 1'b0;
        shift_q <= {32'hFFFF_FFFF, 2'b01, (nw ? 2'b01 : 2'b10),
                    bus_wdata[15:11], bus_wdata[10:6],
                    (nw ? 2'b10 : 2'b00), (nw ? data_q : 16'h0000)};
      end else if (tick) begin
        if (!mdc_q) begin
          mdc_q <= 1'b1;
          if (!wr_q && bit_q >= 6'(DATA_FIRST)) data_q <= {data_q[14:0], mdio_i};
        end else begin
          mdc_q <= 1'b0;
          if (last) busy_q <= 1'b0;
          else begin
            bit_q   <= bit_q + 1'b1;
            shift_q <= {shift_q[62:0], 1'b0};
          end
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = shift_q[63];
  assign mdio_oe = busy_q && (wr_q || bit_q < 6'(DRIVEN_BITS));

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CMD_OFS)       bus_rdata = {16'h0, phy_q, reg_q, 4'h0, wr_q, busy_q};
    else if (bus_addr == DATA_OFS) bus_rdata = {16'h0, data_q};
  end
endmodule

module mdio_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_q,
  input logic        wr_q,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [4:0]  phy_q,
  input logic [4:0]  reg_q,
  input logic [15:0] data_q
);
  p_mdc_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc);
  p_mdio_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) && mdc |-> $stable(mdio_o));
  p_end_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $fell(mdc));
  p_fields_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(phy_q) && $stable(reg_q) && $stable(wr_q));
  p_data_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) && wr_q |-> $stable(data_q));
  p_write_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && wr_q |-> mdio_oe);
  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) && busy_q |-> !wr_q);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_q(busy_q), .wr_q(wr_q), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .phy_q(phy_q), .reg_q(reg_q), .data_q(data_q)
);

// File: tb/sim_mdio_mgmt_ctrl.sv
module sim_mdio_mgmt_ctrl;
  localparam int PERIOD = 10;
  localparam int DIV = 4;
  localparam logic [7:0] CMD = 8'h14;
  localparam logic [7:0] DAT = 8'h18;
  localparam int NV = 5;
  // {write, phy, reg, write value, phy response}
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 5'd1,  5'd0,  16'h1234, 16'h0000},
    {1'b0, 5'd31, 5'd31, 16'h0000, 16'hA5C3},
    {1'b1, 5'd21, 5'd10, 16'hFFFF, 16'h0000},
    {1'b0, 5'd0,  5'd1,  16'h0000, 16'h0001},
    {1'b0, 5'd18, 5'd7,  16'h0000, 16'h8000}
  };

  logic clk = 0, rst_n = 0, bus_wr = 0, mdio_i = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, fails = 0, rc = 0;
  logic [63:0] fr = 0, om = 0;
  logic [15:0] rsp = 0;
  bit done = 0;

  mdio_mgmt_ctrl #(.ADDR_W(8), .DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(PERIOD/2) clk = ~clk;

  initial forever begin
    @(posedge mdc);
    rc++;
    fr = {fr[62:0], mdio_oe ? mdio_o : 1'b0};
    om = {om[62:0], mdio_oe};
  end

  initial forever begin
    @(negedge mdc);
    if (rc >= 48 && rc <= 63) mdio_i = rsp[63-rc];
    else mdio_i = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_done(output int nb, output int nh);
    logic [31:0] v;
    nb = 0; nh = 0;
    forever begin
      rd(CMD, v);
      if (!v[0]) break;
      nb++;
      if (mdc) nh++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] cmdw(input logic w, input logic [4:0] p, input logic [4:0] r, input logic b);
    return {16'h0, p, r, 4'h0, w, b};
  endfunction

  function automatic logic [63:0] efr(input logic w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, (w ? 2'b10 : 2'b00), (w ? d : 16'h0)};
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog R4 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int nb, nh;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(CMD, v); chk(v == 0, "R1 cmd", v, 0);
    rd(DAT, v); chk(v == 0, "R1 data", v, 0);
    chk(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 0);

    for (int i = 0; i < NV; i++) begin
      logic w; logic [4:0] p, r; logic [15:0] d, resp;
      {w, p, r, d, resp} = VEC[i];
      rsp = resp;
      if (w) begin
        wr(DAT, {16'hDEAD, d});
        rd(DAT, v); chk(v == {16'h0, d}, "R3 data load", v, {16'h0, d});
      end
      rc = 0;
      wr(CMD, cmdw(w, p, r, 1'b1));
      rd(CMD, v); chk(v == cmdw(w, p, r, 1'b1), "R2 readback busy", v, cmdw(w, p, r, 1'b1));
      wait_done(nb, nh);
      chk(nb == 64 * DIV, "R4 busy length", nb, 64 * DIV);
      chk(nh == 32 * DIV, "R7 mdc high time", nh, 32 * DIV);
      chk(rc == 64, "R4 mdc periods", rc, 64);
      if (w) begin
        chk(fr == efr(w, p, r, d), "R5 write frame", fr, efr(w, p, r, d));
        chk(om == '1, "R5 write oe", om, '1);
        rd(DAT, v); chk(v == {16'h0, d}, "R3 data kept", v, {16'h0, d});
      end else begin
        chk(fr == efr(w, p, r, d), "R6 read frame", fr, efr(w, p, r, d));
        chk(om == {46'h3FFF_FFFF_FFFF, 18'h0}, "R6 read oe", om, {46'h3FFF_FFFF_FFFF, 18'h0});
        rd(DAT, v); chk(v == {16'h0, resp}, "R6 read value", v, {16'h0, resp});
      end
      rd(CMD, v); chk(v == cmdw(w, p, r, 1'b0), "R2 readback idle", v, cmdw(w, p, r, 1'b0));
    end

    // R8 writes during busy are ignored
    rsp = 16'h5A5A; rc = 0;
    wr(CMD, cmdw(1'b0, 5'd3, 5'd4, 1'b1));
    repeat (100) @(negedge clk);
    wr(CMD, cmdw(1'b1, 5'd9, 5'd9, 1'b1));
    wr(DAT, 32'h0000_1111);
    rd(CMD, v); chk(v == cmdw(1'b0, 5'd3, 5'd4, 1'b1), "R8 cmd ignored", v, cmdw(1'b0, 5'd3, 5'd4, 1'b1));
    wait_done(nb, nh);
    chk(fr == efr(1'b0, 5'd3, 5'd4, 16'h0), "R8 frame intact", fr, efr(1'b0, 5'd3, 5'd4, 16'h0));
    rd(DAT, v); chk(v == 32'h5A5A, "R8 data ignored", v, 32'h5A5A);
    repeat (4 * DIV) @(negedge clk);
    chk(rc == 64, "R8 no second frame", rc, 64);

    // R9 command without start bit
    rc = 0;
    wr(CMD, cmdw(1'b1, 5'd7, 5'd2, 1'b0));
    rd(CMD, v); chk(v == cmdw(1'b1, 5'd7, 5'd2, 1'b0), "R9 fields only", v, cmdw(1'b1, 5'd7, 5'd2, 1'b0));
    repeat (20) @(negedge clk);
    chk(rc == 0 && !mdc && !mdio_oe, "R9 no frame", {rc[3:0], mdc, mdio_oe}, 0);
    finish_run();
  end
endmodule